// File: doc/BRIEF.md
# PCI Configuration Mechanism Translator

This block sits on the host side of a PCI hierarchy and turns software I/O accesses into configuration requests. Software first writes a full 32-bit word to the address port at 0CF8h. That word names an enable, a bus, a device, a function and a dword register index. A later access to the data window at 0CFCh..0CFFh then starts one configuration request toward the bus logic.

The request carries a formatted address-phase word, a read/write command, active-high byte enables and lane-aligned write data. The block holds the I/O access open until the bus side acknowledges, and then completes it with read data placed on the accessed lanes. Two address formats are produced. If the named bus equals the `local_bus` input, the block builds a Type 0 word, in which one upper address line acts as the device select. If the bus differs, it builds a Type 1 word that forwards all the fields unchanged to a downstream bridge.

Top module: `cfg_mech1_bridge`

## Requirements
- R1: After reset the address register reads 0, `cfg_req` is low and `io_ready` is low.
- R2: A 32-bit access (io_size=2) at byte address 0CF8h writes or reads the address register. Bits 30..24 and 1..0 always read back as 0. Bit 31 (enable), bits 23..16 (bus), 15..11 (device), 10..8 (function) and 7..2 (register index) keep the value written.
- R3: An 8- or 16-bit access anywhere in 0CF8h..0CFBh leaves the address register unchanged and completes with read data 0.
- R4: While enable bit 31 is 0, a data-window access starts no request. A read returns 0xFF on every accessed lane and 0 on the other lanes. A write is dropped.
- R5: If the bus field equals `local_bus`, the request address is a Type 0 word. Bits 1..0 are 00, bits 7..2 hold the register index and bits 10..8 hold the function. Of bits 31..11, only bit 11+device is 1.
- R6: If the bus field differs from `local_bus`, the request address is a Type 1 word. Bits 31..24 are 0, bits 23..16 hold the bus, 15..11 the device, 10..8 the function, 7..2 the register index, and bits 1..0 are 01.
- R7: In the Type 0 case, a device number above 20 starts no request. Reads return all ones on the accessed lanes.
- R8: io_size encodes 0 = 8-bit, 1 = 16-bit and 2 = 32-bit, and io_addr[1:0] is the byte offset. `cfg_be[k]` is 1 for each accessed lane k. An access that would cross the end of the 0CFCh dword starts no request and completes with data 0.
- R9: `cfg_req`, `cfg_addr`, `cfg_be`, `cfg_wr` and `cfg_wdata` stay steady until `cfg_ack` is sampled. `io_ready` follows on the next cycle. Read data keeps only the accessed lanes. Write data has 0 on lanes that are not accessed, and writes return data 0.
- R10: `io_ready` is a one-cycle pulse for every access. An access to any other I/O address completes with data 0 and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_bus | input | 8 | Bus number that selects the Type 0 format |
| io_req | input | 1 | I/O access request, held until io_ready |
| io_wr | input | 1 | 1 = I/O write, 0 = I/O read |
| io_addr | input | IO_AW | I/O byte address |
| io_size | input | 2 | 0 = byte, 1 = word, 2 = dword |
| io_wdata | input | 32 | Lane-aligned write data |
| io_ready | output | 1 | One-cycle completion pulse |
| io_rdata | output | 32 | Lane-aligned read data, valid with io_ready |
| cfg_req | output | 1 | Configuration request, held until cfg_ack |
| cfg_wr | output | 1 | Request command: 1 = write |
| cfg_addr | output | 32 | Address-phase word (Type 0 or Type 1) |
| cfg_be | output | 4 | Active-high byte enables |
| cfg_wdata | output | 32 | Write data, masked to the enabled lanes |
| cfg_ack | input | 1 | Completion from the bus side |
| cfg_rdata | input | 32 | Read data from the bus side |

## Verification
Two outcomes are hard to reach from the ports: device 21 in Type 0 form, and a bus number that flips the format. Each needs a prior address-port write followed by a window access, and the local bus number has to change between two runs that use the same stored word. The bench reaches both by rewriting the address port between scenarios. It also changes `local_bus` while the stored word stays fixed, so the same tuple is seen in both formats. A target model stalls the acknowledge for several cycles, which makes the hold-until-acknowledge behaviour and the lane masking visible on narrow reads.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;
  localparam int unsigned IDSEL_LO = 11;
  localparam int unsigned MAX_DEV  = 31 - IDSEL_LO;
  localparam logic [31:0] KEEP_MASK = 32'h80FF_FFFC;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_RESP} seq_state_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_WORD: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic span_ok(input logic [1:0] sz, input logic [1:0] off);
    return ({1'b0, off} + size_bytes(sz)) <= 3'd4;
  endfunction

  function automatic logic [3:0] lane_be(input logic [1:0] sz, input logic [1:0] off);
    logic [3:0] base;
    case (sz)
      SZ_BYTE: base = 4'b0001;
      SZ_WORD: base = 4'b0011;
      default: base = 4'b1111;
    endcase
    return base << off;
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction

  function automatic logic [31:0] type0_word(input logic [4:0] dev, input logic [2:0] fn,
                                             input logic [5:0] rg);
    logic [31:0] w;
    w = 32'd1 << (6'(dev) + 6'(IDSEL_LO));
    w[10:0] = {fn, rg, 2'b00};
    return w;
  endfunction

  function automatic logic [31:0] type1_word(input logic [7:0] bus, input logic [4:0] dev,
                                             input logic [2:0] fn, input logic [5:0] rg);
    return {8'h00, bus, dev, fn, rg, 2'b01};
  endfunction
endpackage

// File: rtl/cfgm_addr_reg.sv
module cfgm_addr_reg
  import cfgm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n)     word <= '0;
    else if (wr_en) word <= wdata & KEEP_MASK;
  end
endmodule

// File: rtl/cfgm_fmt.sv
module cfgm_fmt
  import cfgm_pkg::*;
(
  input  logic [31:0] areg,
  input  logic [7:0]  local_bus,
  output logic        is_type0,
  output logic        has_target,
  output logic [31:0] cyc_word
);
  logic [7:0] bus;
  logic [4:0] dev;
  logic [2:0] fn;
  logic [5:0] rg;

  always_comb begin
    bus        = areg[23:16];
    dev        = areg[15:11];
    fn         = areg[10:8];
    rg         = areg[7:2];
    is_type0   = (bus == local_bus);
    has_target = !is_type0 || (32'(dev) <= MAX_DEV);
    cyc_word   = is_type0 ? type0_word(dev, fn, rg) : type1_word(bus, dev, fn, rg);
  end
endmodule

// File: rtl/cfgm_seq.sv
module cfgm_seq
  import cfgm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        launch,
  input  logic        rd_areg,
  input  logic        rd_ones,
  input  logic        io_wr,
  input  logic [31:0] io_wdata,
  input  logic [3:0]  be,
  input  logic [31:0] areg,
  input  logic [31:0] cyc_word,
  output logic        idle,
  output logic        io_ready,
  output logic [31:0] io_rdata,
  output logic        cfg_req,
  output logic        cfg_wr,
  output logic [31:0] cfg_addr,
  output logic [3:0]  cfg_be,
  output logic [31:0] cfg_wdata,
  input  logic        cfg_ack,
  input  logic [31:0] cfg_rdata
);
  seq_state_e  state;
  logic [31:0] rmask;

  assign idle = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      io_ready  <= 1'b0;
      io_rdata  <= '0;
      cfg_req   <= 1'b0;
      cfg_wr    <= 1'b0;
      cfg_addr  <= '0;
      cfg_be    <= '0;
      cfg_wdata <= '0;
      rmask     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          if (launch) begin
            state     <= ST_BUS;
            cfg_req   <= 1'b1;
            cfg_wr    <= io_wr;
            cfg_addr  <= cyc_word;
            cfg_be    <= be;
            cfg_wdata <= io_wdata & lane_mask(be);
            rmask     <= lane_mask(be);
          end else begin
            state    <= ST_RESP;
            io_ready <= 1'b1;
            io_rdata <= rd_areg ? areg : (rd_ones ? lane_mask(be) : 32'd0);
          end
        end
        ST_BUS: if (cfg_ack) begin
          state    <= ST_RESP;
          cfg_req  <= 1'b0;
          io_ready <= 1'b1;
          io_rdata <= cfg_wr ? 32'd0 : (cfg_rdata & rmask);
        end
        default: begin
          state    <= ST_IDLE;
          io_ready <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/cfg_mech1_bridge.sv
module cfg_mech1_bridge
  import cfgm_pkg::*;
#(
  parameter int unsigned     IO_AW     = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       local_bus,
  input  logic             io_req,
  input  logic             io_wr,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [1:0]       io_size,
  input  logic [31:0]      io_wdata,
  output logic             io_ready,
  output logic [31:0]      io_rdata,
  output logic             cfg_req,
  output logic             cfg_wr,
  output logic [31:0]      cfg_addr,
  output logic [3:0]       cfg_be,
  output logic [31:0]      cfg_wdata,
  input  logic             cfg_ack,
  input  logic [31:0]      cfg_rdata
);
  localparam logic [IO_AW-1:0] DW_MASK = ~IO_AW'(3);

  logic        idle, start, hit_areg, hit_win, areg_wr_en, launch;
  logic        is_type0, has_target, rd_areg, rd_ones;
  logic [3:0]  be;
  logic [31:0] areg_word, cyc_word;

  assign start      = io_req && idle;
  assign hit_areg   = ((io_addr & DW_MASK) == ADDR_PORT) && (io_size == SZ_DWORD)
                      && (io_addr[1:0] == 2'b00);
  assign hit_win    = ((io_addr & DW_MASK) == DATA_PORT) && span_ok(io_size, io_addr[1:0]);
  assign be         = lane_be(io_size, io_addr[1:0]);
  assign areg_wr_en = start && hit_areg && io_wr;
  assign launch     = hit_win && areg_word[31] && has_target;
  assign rd_areg    = hit_areg && !io_wr;
  assign rd_ones    = hit_win && !io_wr;

  cfgm_addr_reg u_areg (
    .clk(clk), .rst_n(rst_n), .wr_en(areg_wr_en), .wdata(io_wdata), .word(areg_word)
  );

  cfgm_fmt u_fmt (
    .areg(areg_word), .local_bus(local_bus), .is_type0(is_type0),
    .has_target(has_target), .cyc_word(cyc_word)
  );

  cfgm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .launch(launch), .rd_areg(rd_areg),
    .rd_ones(rd_ones), .io_wr(io_wr), .io_wdata(io_wdata), .be(be), .areg(areg_word),
    .cyc_word(cyc_word), .idle(idle), .io_ready(io_ready), .io_rdata(io_rdata),
    .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata)
  );
endmodule

// File: rtl/cfgm_checker.sv
module cfgm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        io_ready,
  input logic        cfg_req,
  input logic        cfg_ack,
  input logic [31:0] cfg_addr,
  input logic [3:0]  cfg_be,
  input logic [31:0] areg_word
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    areg_word[30:24] == 7'd0 && areg_word[1:0] == 2'd0); // R2
  AST_NO_CYC_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req) |-> $past(areg_word[31])); // R4
  AST_T0_ONE_IDSEL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_addr[1:0] == 2'b00 |-> $countones(cfg_addr[31:11]) == 1); // R5
  AST_T1_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> !cfg_addr[1] && (!cfg_addr[0] || cfg_addr[31:24] == 8'd0)); // R6
  AST_BE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> cfg_be != 4'd0); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> cfg_req && $stable(cfg_addr) && $stable(cfg_be)); // R9
  AST_ACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_ack |=> !cfg_req && io_ready); // R9
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    io_ready |=> !io_ready); // R10
endmodule

bind cfg_mech1_bridge cfgm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .io_ready(io_ready), .cfg_req(cfg_req), .cfg_ack(cfg_ack),
  .cfg_addr(cfg_addr), .cfg_be(cfg_be), .areg_word(areg_word)
);

// File: tb/cfg_mech1_bridge_tb.sv
module cfg_mech1_bridge_tb;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  local_bus = 0;
  logic        io_req = 0, io_wr = 0;
  logic [15:0] io_addr = 0;
  logic [1:0]  io_size = 0;
  logic [31:0] io_wdata = 0;
  logic        io_ready;
  logic [31:0] io_rdata;
  logic        cfg_req, cfg_wr;
  logic [31:0] cfg_addr, cfg_wdata;
  logic [3:0]  cfg_be;
  logic        cfg_ack = 0;
  logic [31:0] cfg_rdata = 0;

  localparam logic [31:0] TGT = 32'h1234_5678;
  int n_chk = 0, n_err = 0, ncyc = 0, wait_n = 0;
  logic [31:0] cap_addr, cap_wd, first_addr;
  logic [3:0]  cap_be;
  logic        cap_wr, moved = 0;

  always #2.5 clk = ~clk;

  cfg_mech1_bridge u_dut (.*);

  // bus-side target: acknowledges after a short stall
  always @(negedge clk) begin
    if (cfg_ack) cfg_ack = 0;
    else if (cfg_req) begin
      if (wait_n == 0) first_addr = cfg_addr;
      if (cfg_addr !== first_addr) moved = 1;
      if (wait_n == 3) begin
        cap_addr = cfg_addr; cap_be = cfg_be; cap_wr = cfg_wr; cap_wd = cfg_wdata;
        cfg_rdata = TGT; cfg_ack = 1; ncyc++; wait_n = 0;
      end else wait_n++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic io_acc(input logic [15:0] a, input logic [1:0] sz, input logic w,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    io_addr = a; io_size = sz; io_wr = w; io_wdata = wd; io_req = 1;
    rd = 'x;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (io_ready) begin rd = io_rdata; break; end
    end
    io_req = 0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] t0(input int dev, input int fn, input int rg);
    return (32'h1 << (dev + 11)) + fn * 256 + rg * 4;
  endfunction

  function automatic logic [31:0] t1(input int bus, input int dev, input int fn, input int rg);
    return bus * 65536 + dev * 2048 + fn * 256 + rg * 4 + 1;
  endfunction

  function automatic logic [31:0] sel(input int bus, input int dev, input int fn, input int rg);
    return 32'h8000_0000 + bus * 65536 + dev * 2048 + fn * 256 + rg * 4;
  endfunction

  logic [31:0] rd;
  int c0;

  task automatic t_reset();
    check("R1 io_ready", {31'd0, io_ready}, 0);
    check("R1 cfg_req", {31'd0, cfg_req}, 0);
    io_acc(16'h0CF8, 2, 0, 0, rd);
    check("R1 areg", rd, 0);
  endtask

  task automatic t_areg_rw();
    io_acc(16'h0CF8, 2, 1, 32'hFFFF_FFFF, rd);
    io_acc(16'h0CF8, 2, 0, 0, rd);
    check("R2 reserved masked", rd, 32'h80FF_FFFC);
    io_acc(16'h0CF8, 2, 1, 32'h0123_4567, rd);
    io_acc(16'h0CF8, 2, 0, 0, rd);
    check("R2 fields kept", rd, 32'h0023_4564);
  endtask

  task automatic t_areg_narrow();
    io_acc(16'h0CF8, 2, 1, 32'h8001_0800, rd);
    io_acc(16'h0CFB, 0, 1, 32'h0000_0000, rd);
    io_acc(16'h0CFA, 1, 1, 32'hAAAA_AAAA, rd);
    io_acc(16'h0CF8, 0, 0, 0, rd);
    check("R3 narrow read data", rd, 0);
    io_acc(16'h0CF8, 2, 0, 0, rd);
    check("R3 areg unchanged", rd, 32'h8001_0800);
  endtask

  task automatic t_disabled();
    io_acc(16'h0CF8, 2, 1, 32'h0000_0810, rd);
    c0 = ncyc;
    io_acc(16'h0CFC, 2, 0, 0, rd);
    check("R4 read ones", rd, 32'hFFFF_FFFF);
    io_acc(16'h0CFD, 0, 1, 32'h0000_5500, rd);
    check("R4 no cycle", ncyc - c0, 0);
  endtask

  task automatic t_type0();
    local_bus = 0;
    io_acc(16'h0CF8, 2, 1, sel(0, 3, 2, 5), rd);
    io_acc(16'h0CFC, 2, 0, 0, rd);
    check("R5 t0 addr", cap_addr, t0(3, 2, 5));
    check("R5 t0 read data", rd, TGT);
    io_acc(16'h0CF8, 2, 1, sel(0, 20, 7, 63), rd);
    io_acc(16'h0CFC, 2, 0, 0, rd);
    check("R5 t0 dev20 addr", cap_addr, t0(20, 7, 63));
    io_acc(16'h0CF8, 2, 1, sel(0, 0, 0, 0), rd);
    io_acc(16'h0CFC, 2, 0, 0, rd);
    check("R5 t0 dev0 addr", cap_addr, t0(0, 0, 0));
  endtask

  task automatic t_type1();
    local_bus = 0;
    io_acc(16'h0CF8, 2, 1, sel(5, 3, 2, 5), rd);
    io_acc(16'h0CFC, 2, 0, 0, rd);
    check("R6 t1 addr", cap_addr, t1(5, 3, 2, 5));
    io_acc(16'h0CF8, 2, 1, sel(255, 31, 7, 63), rd);
    io_acc(16'h0CFC, 2, 0, 0, rd);
    check("R6 t1 all-ones fields", cap_addr, t1(255, 31, 7, 63));
    local_bus = 5;
    io_acc(16'h0CF8, 2, 1, sel(5, 3, 2, 5), rd);
    io_acc(16'h0CFC, 2, 0, 0, rd);
    check("R5 local bus 5 gives t0", cap_addr, t0(3, 2, 5));
    local_bus = 0;
  endtask

  task automatic t_no_dev();
    io_acc(16'h0CF8, 2, 1, sel(0, 21, 0, 0), rd);
    c0 = ncyc;
    io_acc(16'h0CFD, 0, 0, 0, rd);
    check("R7 dev21 read", rd, 32'h0000_FF00);
    check("R7 dev21 no cycle", ncyc - c0, 0);
    local_bus = 1;
    io_acc(16'h0CFC, 2, 0, 0, rd);
    check("R7 dev21 on other bus is t1", cap_addr, t1(0, 21, 0, 0));
    local_bus = 0;
  endtask

  task automatic t_lanes();
    io_acc(16'h0CF8, 2, 1, sel(0, 1, 0, 4), rd);
    io_acc(16'h0CFE, 0, 1, 32'hFFAB_FFFF, rd);
    check("R8 byte be", {28'd0, cap_be}, 32'h4);
    check("R9 byte wdata masked", cap_wd, 32'h00AB_0000);
    check("R9 write cmd", {31'd0, cap_wr}, 1);
    check("R9 write returns 0", rd, 0);
    io_acc(16'h0CFE, 1, 0, 0, rd);
    check("R8 word be", {28'd0, cap_be}, 32'hC);
    check("R9 word read masked", rd, 32'h1234_0000);
    io_acc(16'h0CFD, 1, 0, 0, rd);
    check("R8 mid word be", {28'd0, cap_be}, 32'h6);
    check("R9 mid word read", rd, 32'h0034_5600);
    c0 = ncyc;
    io_acc(16'h0CFF, 1, 0, 0, rd);
    check("R8 crossing read 0", rd, 0);
    check("R8 crossing no cycle", ncyc - c0, 0);
    check("R9 request held steady", {31'd0, moved}, 0);
  endtask

  task automatic t_unclaimed();
    c0 = ncyc;
    io_acc(16'h0080, 2, 0, 0, rd);
    check("R10 other port data", rd, 0);
    io_acc(16'h0CF4, 2, 1, 32'h8000_0000, rd);
    check("R10 other port no cycle", ncyc - c0, 0);
    io_acc(16'h0CF8, 2, 0, 0, rd);
    check("R10 areg untouched", rd, sel(0, 1, 0, 4));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_areg_rw();
    t_areg_narrow();
    t_disabled();
    t_type0();
    t_type1();
    t_no_dev();
    t_lanes();
    t_unclaimed();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule